// File: doc/BRIEF.md
# Per-Pin Standby Retention Status Register

This block keeps one status bit per pin of an I/O port. Each bit records that the pin's output level was held while the chip sat in its deep standby mode. On the cycle the standby-entry pulse arrives, every pin whose retention enable input is high gets its bit set. Software acknowledges a pin by writing a zero to its bit. Writing a one to a bit leaves it unchanged.

Each pin can be assigned to the secure domain through its own configuration input. Every access carries two attributes, secure and privileged, and each bit is filtered on its own. A non-secure access cannot see or change a secure bit. An unprivileged access is turned away when the privilege-protection input for that bit's domain is raised. A refused access reads zero and drops its write without signalling an error, so a filtered access cannot be told apart from one that hits an empty bit.

One bit position can be left out by parameter (position 4 by default). That position always reads zero. Read data is registered and arrives one cycle after the read strobe.

Top module: `ret_status_reg`

## Requirements
- R1: After reset every status bit is 0, so a read returns 0x0000.
- R2: A bit becomes 1 on the clock edge where `standby_entry` is high and that pin's `ret_enable` bit is high. A pulse with the enable low leaves the bit at 0.
- R3: A permitted write clears each implemented bit whose `wdata` bit is 0. A `wdata` bit of 1 leaves its status bit unchanged.
- R4: For a pin with `pin_secure` high, an access with `acc_secure` low reads that bit as 0 and its write does not change that bit.
- R5: An access with `acc_priv` low is refused for a secure pin while `sec_priv_only` is high, and for a non-secure pin while `ns_priv_only` is high. A refused bit reads 0 and is not written.
- R6: The unimplemented position (bit 4 with the defaults) always reads 0 and is never set by a standby entry.
- R7: When a standby-entry set and a permitted write of 0 hit the same bit in the same cycle, the bit ends up 1.
- R8: `rdata` shows the filtered status one cycle after the cycle in which `rd_en` is high. In any cycle that does not follow a read it is 0.
- R9: A secure, privileged access reads and clears both secure and non-secure bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_entry | input | 1 | Single-cycle pulse marking standby entry |
| ret_enable | input | NBITS | Per-pin retention enable, sampled on the pulse |
| pin_secure | input | NBITS | Per-pin secure-domain assignment |
| sec_priv_only | input | 1 | Refuse unprivileged access to secure bits |
| ns_priv_only | input | 1 | Refuse unprivileged access to non-secure bits |
| acc_secure | input | 1 | Current access is secure |
| acc_priv | input | 1 | Current access is privileged |
| wr_en | input | 1 | Write strobe |
| wdata | input | NBITS | Write data (0 clears, 1 keeps) |
| rd_en | input | 1 | Read strobe |
| rdata | output | NBITS | Registered, filtered read data |

## Verification
The checker relies on two things. `standby_entry` is a pulse whose enable vector is valid in the same cycle. The secure and privilege attributes are steady for the whole cycle of the strobe they qualify. Under these conditions the checker can treat a status bit that falls as the work of a permitted write alone. The bench drives every strobe, attribute and configuration input on the falling edge and holds it over the following rising edge. It raises the standby pulse for exactly one cycle, and it keeps the pin-domain and protection inputs fixed across each stimulus vector, so every expected read value follows from that vector by itself.

// File: rtl/ret_status_pkg.sv
package ret_status_pkg;

   // Decide whether one bit may be touched by an access with the given attributes.
   function automatic logic bit_allowed(
      input logic bit_secure,
      input logic acc_secure,
      input logic acc_priv,
      input logic sec_priv_only,
      input logic ns_priv_only
   );
      logic domain_ok;
      logic priv_ok;
      domain_ok = !bit_secure || acc_secure;
      priv_ok   = acc_priv || !(bit_secure ? sec_priv_only : ns_priv_only);
      return domain_ok && priv_ok;
   endfunction

endpackage

// File: rtl/ret_access_filter.sv
module ret_access_filter #(
   parameter int unsigned NBITS = 16
) (
   input  logic [NBITS-1:0] pin_secure,
   input  logic             acc_secure,
   input  logic             acc_priv,
   input  logic             sec_priv_only,
   input  logic             ns_priv_only,
   output logic [NBITS-1:0] allow
);
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      assign allow[i] = ret_status_pkg::bit_allowed(pin_secure[i], acc_secure, acc_priv,
                                                    sec_priv_only, ns_priv_only);
   end
endmodule

// File: rtl/ret_status_bits.sv
module ret_status_bits #(
   parameter int unsigned      NBITS     = 16,
   parameter logic [NBITS-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby_entry,
   input  logic [NBITS-1:0] ret_enable,
   input  logic             wr_en,
   input  logic [NBITS-1:0] wdata,
   input  logic [NBITS-1:0] wr_allow,
   output logic [NBITS-1:0] status
);
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         logic hw_set;
         logic sw_clr;
         assign hw_set = standby_entry && ret_enable[i];
         assign sw_clr = wr_en && wr_allow[i] && !wdata[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status[i] <= 1'b0;
            else if (hw_set) status[i] <= 1'b1;
            else if (sw_clr) status[i] <= 1'b0;
         end
      end else begin : g_hole
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/ret_read_port.sv
module ret_read_port #(
   parameter int unsigned NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [NBITS-1:0] status,
   input  logic [NBITS-1:0] rd_allow,
   output logic [NBITS-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= status & rd_allow;
      else            rdata <= '0;
   end
endmodule

// File: rtl/ret_status_reg.sv
module ret_status_reg #(
   parameter int unsigned NBITS    = 16,
   parameter bit          HAS_HOLE = 1'b1,
   parameter int unsigned HOLE_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby_entry,
   input  logic [NBITS-1:0] ret_enable,
   input  logic [NBITS-1:0] pin_secure,
   input  logic             sec_priv_only,
   input  logic             ns_priv_only,
   input  logic             acc_secure,
   input  logic             acc_priv,
   input  logic             wr_en,
   input  logic [NBITS-1:0] wdata,
   input  logic             rd_en,
   output logic [NBITS-1:0] rdata
);
   localparam logic [NBITS-1:0] ONE_HOT_HOLE = NBITS'(1) << HOLE_BIT;
   localparam logic [NBITS-1:0] IMPL_MASK    = HAS_HOLE ? ~ONE_HOT_HOLE : '1;

   if (NBITS < 1 || NBITS > 32) begin : g_bad_width
      $error("ret_status_reg: NBITS must be 1..32");
   end
   if (HAS_HOLE && HOLE_BIT >= NBITS) begin : g_bad_hole
      $error("ret_status_reg: HOLE_BIT outside the register");
   end

   logic [NBITS-1:0] allow;
   logic [NBITS-1:0] status_q;

   ret_access_filter #(.NBITS(NBITS)) u_filter (
      .pin_secure   (pin_secure),
      .acc_secure   (acc_secure),
      .acc_priv     (acc_priv),
      .sec_priv_only(sec_priv_only),
      .ns_priv_only (ns_priv_only),
      .allow        (allow)
   );

   ret_status_bits #(.NBITS(NBITS), .IMPL_MASK(IMPL_MASK)) u_bits (
      .clk          (clk),
      .rst_n        (rst_n),
      .standby_entry(standby_entry),
      .ret_enable   (ret_enable),
      .wr_en        (wr_en),
      .wdata        (wdata),
      .wr_allow     (allow),
      .status       (status_q)
   );

   ret_read_port #(.NBITS(NBITS)) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .status  (status_q),
      .rd_allow(allow),
      .rdata   (rdata)
   );
endmodule

// File: rtl/ret_status_chk.sv
module ret_status_chk #(
   parameter int unsigned      NBITS     = 16,
   parameter logic [NBITS-1:0] IMPL_MASK = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             standby_entry,
   input logic [NBITS-1:0] ret_enable,
   input logic [NBITS-1:0] pin_secure,
   input logic             sec_priv_only,
   input logic             acc_secure,
   input logic             acc_priv,
   input logic             wr_en,
   input logic             rd_en,
   input logic [NBITS-1:0] status_q,
   input logic [NBITS-1:0] rdata
);
   // R2 R7
   standby_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_entry |=> ((status_q & $past(ret_enable & IMPL_MASK)) == $past(ret_enable & IMPL_MASK)));

   // R3
   no_fall_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R4
   ns_write_keeps_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !acc_secure) |=> (((~status_q) & $past(status_q & pin_secure)) == '0));

   // R4
   ns_read_hides_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !acc_secure) |=> ((rdata & $past(pin_secure)) == '0));

   // R5
   unpriv_write_keeps_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !acc_priv && sec_priv_only) |=> (((~status_q) & $past(status_q & pin_secure)) == '0));

   // R6
   hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdata & ~IMPL_MASK) == '0));

   // R8
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));
endmodule

bind ret_status_reg ret_status_chk #(.NBITS(NBITS), .IMPL_MASK(IMPL_MASK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .standby_entry(standby_entry),
   .ret_enable   (ret_enable),
   .pin_secure   (pin_secure),
   .sec_priv_only(sec_priv_only),
   .acc_secure   (acc_secure),
   .acc_priv     (acc_priv),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .status_q     (status_q),
   .rdata        (rdata)
);

// File: tb/ret_status_reg_tb.sv
`timescale 1ns/1ps
module ret_status_reg_tb;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         standby_entry = 1'b0;
   logic [W-1:0] ret_enable = '0;
   logic [W-1:0] pin_secure = '0;
   logic         sec_priv_only = 1'b0;
   logic         ns_priv_only = 1'b0;
   logic         acc_secure = 1'b0;
   logic         acc_priv = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wdata = '0;
   logic         rd_en = 1'b0;
   logic [W-1:0] rdata;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   ret_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .standby_entry(standby_entry), .ret_enable(ret_enable),
      .pin_secure(pin_secure), .sec_priv_only(sec_priv_only), .ns_priv_only(ns_priv_only),
      .acc_secure(acc_secure), .acc_priv(acc_priv), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata)
   );

   typedef struct packed {
      logic [W-1:0] en;     // standby pulse with this enable (0: no pulse)
      logic         wr;
      logic [W-1:0] wd;
      logic         w_sec;
      logic         w_priv;
      logic         r_sec;
      logic         r_priv;
      logic [W-1:0] psec;
      logic         sp;
      logic         nsp;
      logic [W-1:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R2 all pins enabled, hole stays 0
      '{16'hFFFF, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'hFFEF},
      // R2 partial enable
      '{16'h00A5, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h00A5},
      // R3 zeros clear, ones keep
      '{16'hFFFF, 1'b1, 16'hF0F0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'hF0E0},
      // R4 non-secure write cannot clear secure bits
      '{16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00FF, 1'b0, 1'b0, 16'h00EF},
      // R4 non-secure read hides secure bits
      '{16'hFFFF, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00FF, 1'b0, 1'b0, 16'hFF00},
      // R5 secure protection blocks unprivileged clear of secure bits
      '{16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b0, 16'h0F0F},
      // R5 non-secure protection blocks unprivileged clear of non-secure bits
      '{16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F, 1'b0, 1'b1, 16'hF0E0},
      // R5 unprivileged read of protected secure bits returns 0 there
      '{16'hFFFF, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0F0F, 1'b1, 1'b0, 16'hF0E0},
      // R9 secure privileged read of all-secure port
      '{16'h1234, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h1224},
      // R6 enabling only the hole sets nothing
      '{16'h0010, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000}
   };

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic pulse_standby(input logic [W-1:0] en);
      @(negedge clk);
      standby_entry = 1'b1;
      ret_enable    = en;
      @(negedge clk);
      standby_entry = 1'b0;
      ret_enable    = '0;
   endtask

   task automatic do_write(input logic [W-1:0] d, input logic s, input logic p);
      @(negedge clk);
      wr_en = 1'b1; wdata = d; acc_secure = s; acc_priv = p;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic do_read(input logic s, input logic p, output logic [W-1:0] v);
      @(negedge clk);
      rd_en = 1'b1; acc_secure = s; acc_priv = p;
      @(negedge clk);
      v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic clear_all();
      logic [W-1:0] keep_sec;
      logic         keep_sp;
      logic         keep_nsp;
      keep_sec = pin_secure; keep_sp = sec_priv_only; keep_nsp = ns_priv_only;
      sec_priv_only = 1'b0; ns_priv_only = 1'b0;
      do_write('0, 1'b1, 1'b1);
      pin_secure = keep_sec; sec_priv_only = keep_sp; ns_priv_only = keep_nsp;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      do_read(1'b1, 1'b1, v);
      check("R1 reset", v, 16'h0000);

      foreach (VECS[k]) begin
         pin_secure    = VECS[k].psec;
         sec_priv_only = VECS[k].sp;
         ns_priv_only  = VECS[k].nsp;
         if (VECS[k].en != '0) pulse_standby(VECS[k].en);
         if (VECS[k].wr) do_write(VECS[k].wd, VECS[k].w_sec, VECS[k].w_priv);
         do_read(VECS[k].r_sec, VECS[k].r_priv, v);
         check($sformatf("vector %0d", k), v, VECS[k].exp);
         clear_all();
      end
      pin_secure = '0; sec_priv_only = 1'b0; ns_priv_only = 1'b0;

      // R2 pulse with enable low sets nothing
      pulse_standby('0);
      do_read(1'b1, 1'b1, v);
      check("R2 no enable", v, 16'h0000);

      // R3 writing ones has no effect
      pulse_standby(16'h0002);
      do_write(16'hFFFF, 1'b1, 1'b1);
      do_read(1'b1, 1'b1, v);
      check("R3 write ones", v, 16'h0002);
      clear_all();

      // R7 set and clear in the same cycle: set wins
      @(negedge clk);
      standby_entry = 1'b1; ret_enable = 16'h0001;
      wr_en = 1'b1; wdata = 16'h0000; acc_secure = 1'b1; acc_priv = 1'b1;
      @(negedge clk);
      standby_entry = 1'b0; ret_enable = '0; wr_en = 1'b0;
      do_read(1'b1, 1'b1, v);
      check("R7 set wins", v, 16'h0001);

      // R8 no read in the previous cycle gives zero
      @(negedge clk);
      check("R8 idle zero", rdata, 16'h0000);
      clear_all();
      do_read(1'b1, 1'b1, v);
      check("R9 secure clear", v, 16'h0000);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule